// File: doc/BRIEF.md
# Multiplexed DRAM Bus to SRAM Adapter

This block sits between a memory controller built for row/column multiplexed DRAM and a static RAM array that stores 16-bit words as two byte lanes. It watches the controller's active-low row strobe, column strobe and two per-lane write strobes, together with a 9-bit multiplexed address bus and an 8-bit data bus. From them it assembles a flat SRAM word address, raises chip select for the duration of each real access, and fires one-cycle write enables per byte lane.

All strobes and bus values pass through a synchronizer clocked by a system clock at least four times faster than the strobes. Edges are found on the synchronized values. A row strobe that is never followed by a column strobe is a refresh cycle and leaves the SRAM alone.

Reads follow the controller's two-byte habit. One byte of the addressed word is returned while the column strobe is low. The other byte is latched and presented after the column strobe rises. The controller may cut the column-high period short, or open a second column inside the same row cycle, and neither corrupts state.

Top module: `mdram_sram_bridge`

## Requirements
- R1: The row phase of `maddr`, taken when the synchronized row strobe falls, appears on `sram_addr[8:0]`. The column phase, taken when the synchronized column strobe falls, appears on `sram_addr[17:9]`.
- R2: `sram_cs` goes high on the edge that detects a column strobe fall while the row strobe is low. It stays high until the edge that detects the row strobe rising.
- R3: `bank_sel`, sampled at the row strobe fall, appears on `sram_addr[18]` and selects one of two banks of 256K words.
- R4: `sram_we[i]` is a one-cycle pulse on the first clock where chip select is high, the row strobe is low, the column strobe has been low for two samples and `wen_n[i]` is low. `sram_wdata` on that cycle is the data bus value from the same sample. There is at most one pulse per lane for each column strobe fall.
- R5: Lane 0 (bits 7:0 of the SRAM word) is written only by `wen_n[0]`, and lane 1 (bits 15:8) only by `wen_n[1]`. A write on one lane leaves the other byte unchanged.
- R6: A row strobe cycle with no column strobe fall raises neither `sram_cs`, `sram_we`, `bus_oe` nor `acc_done`.
- R7: `bus_oe` is high from the column strobe fall, when both write strobes are high, until the row strobe rise. While the synchronized column strobe is low, `bus_rdata` shows lane 0 of the addressed word.
- R8: After the synchronized column strobe rises, `bus_rdata` shows lane 1 as it was last read while the column strobe was low. Later changes in the SRAM do not alter it.
- R9: A write strobe seen low during the column-low period drops `bus_oe`, and `bus_oe` is low on any cycle where `sram_we` pulses.
- R10: `acc_done` is a single-cycle pulse on the edge that detects the row strobe rise, and only if chip select was high.
- R11: A column-high period of one sample, followed by a new column fall inside the same row cycle, starts a fresh access at the new column. The read bytes of that column are correct.
- R12: With the default two synchronizer stages, a strobe change driven before clock edge k takes effect on the outputs after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the strobe rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe from the controller, active low |
| cas_n | input | 1 | Column strobe from the controller, active low |
| wen_n | input | 2 | Per-lane write strobes, active low |
| bank_sel | input | 1 | Bank select, sampled with the row |
| maddr | input | 9 | Multiplexed row/column address |
| bus_wdata | input | 8 | Write data from the controller |
| bus_rdata | output | 8 | Read byte returned to the controller |
| bus_oe | output | 1 | High while the adapter drives read data |
| sram_addr | output | 19 | {bank, column, row} word address |
| sram_cs | output | 1 | SRAM chip select, active high |
| sram_we | output | 2 | Per-lane SRAM write pulses |
| sram_wdata | output | 8 | Byte written to the selected lane |
| sram_rdata | input | 16 | Word read from the SRAM |
| acc_done | output | 1 | Pulse at the end of a real access |

## Verification
The assertions watch, on every cycle, that a lane write pulse never lasts two cycles, never occurs without chip select and never overlaps read drive. They also check that the read drive never appears without chip select, that the row address does not move during an access, and that the done pulse follows a closing chip select. Only the bench scenarios can show that the right bytes land in the right lane and bank, that the second read byte survives SRAM changes after the column strobe rises, that refresh cycles touch nothing, and that the three-edge synchronizer latency and a shortened column-high period behave as required.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

   // synchronized strobe group, packed so one synchronizer carries all of it
   typedef struct packed {
      logic       ras_n;
      logic       cas_n;
      logic [1:0] wen_n;
   } strobe_t;

   // width of the strobe group in bits
   localparam int unsigned STROBE_W = $bits(strobe_t);

   // byte lanes per SRAM word; the read return order assumes exactly two
   localparam int unsigned LANES = 2;

endpackage

// File: rtl/dsa_sync.sv
module dsa_sync #(
   parameter int unsigned W       = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dsa_sync needs at least two stages");
      end
      if (W < 1) begin : g_bad_width
         $error("dsa_sync width must be positive");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d};
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/dsa_edge_track.sv
module dsa_edge_track
   import dsa_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  strobe_t now_s,
   output logic    ras_fall,
   output logic    ras_rise,
   output logic    ras_low,
   output logic    cas_fall,
   output logic    cas_held
);

   logic ras_q;
   logic cas_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_q <= 1'b1;
         cas_q <= 1'b1;
      end else begin
         ras_q <= now_s.ras_n;
         cas_q <= now_s.cas_n;
      end
   end

   assign ras_fall = ras_q & ~now_s.ras_n;
   assign ras_rise = ~ras_q & now_s.ras_n;
   assign ras_low  = ~now_s.ras_n;
   // a column fall only counts inside a row cycle; the rest is refresh
   assign cas_fall = cas_q & ~now_s.cas_n & ~now_s.ras_n;
   assign cas_held = ~cas_q & ~now_s.cas_n;

endmodule

// File: rtl/dsa_addr_capture.sv
module dsa_addr_capture #(
   parameter int unsigned PHASE_W = 9,
   parameter int unsigned BANK_W  = 1,
   localparam int unsigned ADDR_W = BANK_W + 2 * PHASE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ras_fall,
   input  logic               ras_rise,
   input  logic               cas_fall,
   input  logic [BANK_W-1:0]  bank_s,
   input  logic [PHASE_W-1:0] maddr_s,
   output logic [ADDR_W-1:0]  addr,
   output logic               cs,
   output logic               done
);

   logic [PHASE_W-1:0] row_q;
   logic [PHASE_W-1:0] col_q;
   logic [BANK_W-1:0]  bank_q;
   logic               cs_q;
   logic               done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q  <= '0;
         bank_q <= '0;
      end else if (ras_fall) begin
         row_q  <= maddr_s;
         bank_q <= bank_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= '0;
      end else if (cas_fall) begin
         col_q <= maddr_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= ras_rise & cs_q;
         if (ras_rise) begin
            cs_q <= 1'b0;
         end else if (cas_fall) begin
            cs_q <= 1'b1;
         end
      end
   end

   assign addr = {bank_q, col_q, row_q};
   assign cs   = cs_q;
   assign done = done_q;

   // R1: the row may not move while an access is open
   a_r1_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_q && $past(cs_q)) |-> $stable(row_q));

   // R10: done only marks a chip select that has just closed
   a_r10_done_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!cs_q && $past(cs_q)));

   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

endmodule

// File: rtl/dsa_lane_write.sv
module dsa_lane_write (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic ras_low,
   input  logic ras_rise,
   input  logic cas_fall,
   input  logic cas_held,
   input  logic wen_n_s,
   output logic fire,
   output logic we
);

   logic we_q;
   logic spent_q;

   assign fire = cs & ras_low & cas_held & ~wen_n_s & ~spent_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q    <= 1'b0;
         spent_q <= 1'b0;
      end else begin
         we_q <= fire;
         if (ras_rise || cas_fall) begin
            spent_q <= 1'b0;
         end else if (fire) begin
            spent_q <= 1'b1;
         end
      end
   end

   assign we = we_q;

   // R4: one column opening gives a lane at most a single-cycle pulse
   a_r4_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      we_q |=> !we_q);

endmodule

// File: rtl/dsa_read_return.sv
module dsa_read_return #(
   parameter int unsigned BYTE_W     = 8,
   parameter int unsigned FIRST_LANE = 0,
   localparam int unsigned WORD_W    = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              ras_rise,
   input  logic              cas_fall,
   input  logic              cas_held,
   input  logic              cas_n_s,
   input  logic [1:0]        wen_n_s,
   input  logic [WORD_W-1:0] rdata,
   output logic              oe,
   output logic [BYTE_W-1:0] dout
);

   logic              rd_q;
   logic [BYTE_W-1:0] hold_q;
   logic [BYTE_W-1:0] first_byte;
   logic [BYTE_W-1:0] second_byte;

   generate
      if (FIRST_LANE == 0) begin : g_low_first
         assign first_byte  = rdata[BYTE_W-1:0];
         assign second_byte = rdata[WORD_W-1:BYTE_W];
      end else if (FIRST_LANE == 1) begin : g_high_first
         assign first_byte  = rdata[WORD_W-1:BYTE_W];
         assign second_byte = rdata[BYTE_W-1:0];
      end else begin : g_bad_lane
         $error("FIRST_LANE must be 0 or 1");
         assign first_byte  = '0;
         assign second_byte = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= 1'b0;
      end else if (ras_rise) begin
         rd_q <= 1'b0;
      end else if (cas_fall) begin
         rd_q <= &wen_n_s;
      end else if (cs && cas_held && !(&wen_n_s)) begin
         rd_q <= 1'b0;
      end
   end

   // second byte follows the SRAM only while the column strobe is low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (rd_q && !cas_n_s) begin
         hold_q <= second_byte;
      end
   end

   assign oe   = rd_q;
   assign dout = cas_n_s ? hold_q : first_byte;

   // R7: read drive exists only inside an open access
   a_r7_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
      rd_q |-> cs);

endmodule

// File: rtl/mdram_sram_bridge.sv
module mdram_sram_bridge
   import dsa_pkg::*;
#(
   parameter int unsigned PHASE_W     = 9,
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned BANKS       = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FIRST_LANE  = 0,
   localparam int unsigned BANK_W     = $clog2(BANKS),
   localparam int unsigned ADDR_W     = BANK_W + 2 * PHASE_W,
   localparam int unsigned WORD_W     = LANES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic [1:0]        wen_n,
   input  logic [BANK_W-1:0] bank_sel,
   input  logic [PHASE_W-1:0] maddr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   output logic              bus_oe,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_cs,
   output logic [1:0]        sram_we,
   output logic [BYTE_W-1:0] sram_wdata,
   input  logic [WORD_W-1:0] sram_rdata,
   output logic              acc_done
);

   localparam int unsigned DP_W = BANK_W + PHASE_W + BYTE_W;

   generate
      if (BANKS < 2 || (BANKS & (BANKS - 1)) != 0) begin : g_bad_banks
         $error("BANKS must be a power of two, at least 2");
      end
      if (PHASE_W < 1 || BYTE_W < 1) begin : g_bad_widths
         $error("PHASE_W and BYTE_W must be positive");
      end
   endgenerate

   // ---------------- synchronizers ----------------
   strobe_t         raw_st;
   strobe_t         syn_st;
   logic [DP_W-1:0] dp_s;

   assign raw_st = '{ras_n: ras_n, cas_n: cas_n, wen_n: wen_n};

   dsa_sync #(
      .W       (STROBE_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ({STROBE_W{1'b1}})
   ) u_strobe_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_st),
      .q     (syn_st)
   );

   // bus values ride the same delay so they line up with the strobes
   dsa_sync #(
      .W       (DP_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ('0)
   ) u_data_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({bank_sel, maddr, bus_wdata}),
      .q     (dp_s)
   );

   logic [BANK_W-1:0]  bank_s;
   logic [PHASE_W-1:0] maddr_s;
   logic [BYTE_W-1:0]  din_s;

   assign {bank_s, maddr_s, din_s} = dp_s;

   // ---------------- edge detection ----------------
   logic ras_fall;
   logic ras_rise;
   logic ras_low;
   logic cas_fall;
   logic cas_held;

   dsa_edge_track u_edges (
      .clk      (clk),
      .rst_n    (rst_n),
      .now_s    (syn_st),
      .ras_fall (ras_fall),
      .ras_rise (ras_rise),
      .ras_low  (ras_low),
      .cas_fall (cas_fall),
      .cas_held (cas_held)
   );

   // ---------------- address and chip select ----------------
   dsa_addr_capture #(
      .PHASE_W (PHASE_W),
      .BANK_W  (BANK_W)
   ) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .ras_fall (ras_fall),
      .ras_rise (ras_rise),
      .cas_fall (cas_fall),
      .bank_s   (bank_s),
      .maddr_s  (maddr_s),
      .addr     (sram_addr),
      .cs       (sram_cs),
      .done     (acc_done)
   );

   // ---------------- per-lane write enables ----------------
   logic [LANES-1:0] lane_fire;

   generate
      for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
         dsa_lane_write u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .cs       (sram_cs),
            .ras_low  (ras_low),
            .ras_rise (ras_rise),
            .cas_fall (cas_fall),
            .cas_held (cas_held),
            .wen_n_s  (syn_st.wen_n[ln]),
            .fire     (lane_fire[ln]),
            .we       (sram_we[ln])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sram_wdata <= '0;
      end else if (|lane_fire) begin
         sram_wdata <= din_s;
      end
   end

   // ---------------- read return ----------------
   dsa_read_return #(
      .BYTE_W     (BYTE_W),
      .FIRST_LANE (FIRST_LANE)
   ) u_read (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs       (sram_cs),
      .ras_rise (ras_rise),
      .cas_fall (cas_fall),
      .cas_held (cas_held),
      .cas_n_s  (syn_st.cas_n),
      .wen_n_s  (syn_st.wen_n),
      .rdata    (sram_rdata),
      .oe       (bus_oe),
      .dout     (bus_rdata)
   );

   // R6: a lane write never happens outside an open access
   a_r6_we_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
      (|sram_we) |-> sram_cs);

   // R9: the adapter never drives the bus while it is writing
   a_r9_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      (|sram_we) |-> !bus_oe);

endmodule

// File: tb/test_mdram_sram_bridge.sv
module test_mdram_sram_bridge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ras_n = 1'b1;
   logic        cas_n = 1'b1;
   logic [1:0]  wen_n = 2'b11;
   logic [0:0]  bank_sel = 1'b0;
   logic [8:0]  maddr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        bus_oe;
   logic [18:0] sram_addr;
   logic        sram_cs;
   logic [1:0]  sram_we;
   logic [7:0]  sram_wdata;
   logic [15:0] sram_rdata;
   logic        acc_done;

   always #5 clk = ~clk;

   mdram_sram_bridge i_mdram_sram_bridge (
      .clk, .rst_n, .ras_n, .cas_n, .wen_n, .bank_sel, .maddr, .bus_wdata,
      .bus_rdata, .bus_oe, .sram_addr, .sram_cs, .sram_we, .sram_wdata,
      .sram_rdata, .acc_done
   );

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   // ---------------- SRAM model ----------------
   logic [15:0] mem [int];
   int mem_gen = 0;

   function automatic logic [7:0] pat_lo(input int a);
      return 8'(a) ^ 8'h5A;
   endfunction
   function automatic logic [7:0] pat_hi(input int a);
      return 8'(a >> 8) ^ 8'(a >> 16) ^ 8'hC3;
   endfunction
   function automatic logic [15:0] word_at(input int a);
      if (mem.exists(a)) return mem[a];
      return {pat_hi(a), pat_lo(a)};
   endfunction
   function automatic int addr_of(input int b, input int r, input int c);
      return (b << 18) | (c << 9) | r;
   endfunction

   always @(sram_addr or mem_gen) sram_rdata = word_at(int'(sram_addr));

   // ---------------- reference model, one step per clock ----------------
   logic [3:0] hq[$];
   logic [8:0] aq[$];
   logic       bq[$];
   logic [7:0] dq[$];
   logic [8:0] m_row, m_col;
   logic       m_bank, m_cs, m_rd, m_done;
   logic [1:0] m_we, m_spent;
   logic [7:0] m_wdata, m_hold;
   int         done_cnt = 0, cs_rise_cnt = 0, we_cnt = 0;
   logic       cs_prev = 0;

   always @(posedge clk) begin
      logic [3:0] v, p;
      logic rfall, rrise, cfall, ocs, ord;
      logic [1:0] ospent;
      int oaddr;
      if (!rst_n) begin
         hq = '{4'hF, 4'hF, 4'hF, 4'hF};
         aq = '{9'd0, 9'd0, 9'd0, 9'd0};
         bq = '{1'b0, 1'b0, 1'b0, 1'b0};
         dq = '{8'd0, 8'd0, 8'd0, 8'd0};
         m_row = 0; m_col = 0; m_bank = 0; m_cs = 0; m_rd = 0; m_done = 0;
         m_we = 0; m_spent = 0; m_wdata = 0; m_hold = 0;
      end else begin
         hq.push_front({ras_n, cas_n, wen_n}); void'(hq.pop_back());
         aq.push_front(maddr); void'(aq.pop_back());
         bq.push_front(bank_sel[0]); void'(bq.pop_back());
         dq.push_front(bus_wdata); void'(dq.pop_back());
         v = hq[2]; p = hq[3];
         rfall = p[3] && !v[3];
         rrise = !p[3] && v[3];
         cfall = p[2] && !v[2] && !v[3];
         oaddr = addr_of(m_bank, m_row, m_col);
         ocs = m_cs; ord = m_rd; ospent = m_spent;
         if (ord && !v[2]) m_hold = word_at(oaddr) >> 8;
         for (int i = 0; i < 2; i++) begin
            m_we[i] = ocs && !v[2] && !p[2] && !v[3] && !v[i] && !ospent[i];
            if (m_we[i]) begin m_spent[i] = 1; m_wdata = dq[2]; end
         end
         if (rfall) begin m_row = aq[2]; m_bank = bq[2]; end
         m_done = rrise && ocs;
         if (rrise) begin
            m_cs = 0; m_rd = 0; m_spent = 0;
         end else if (cfall) begin
            m_col = aq[2]; m_cs = 1; m_rd = &v[1:0]; m_spent = 0;
         end else if (ocs && !v[2] && !p[2] && (v[1:0] != 2'b11)) begin
            m_rd = 0;
         end
         if (acc_done) done_cnt++;
         if (|sram_we) we_cnt++;
         if (sram_cs && !cs_prev) cs_rise_cnt++;
         cs_prev = sram_cs;
      end
   end

   always @(negedge clk) begin
      logic [15:0] w;
      logic [7:0] exp_d;
      int a;
      if (rst_n && !finished) begin
         chk(sram_cs == m_cs, "R2 R6 sram_cs", sram_cs, m_cs);
         chk(bus_oe == m_rd, "R7 R9 bus_oe", bus_oe, m_rd);
         chk(sram_we == m_we, "R4 R5 sram_we", sram_we, m_we);
         chk(acc_done == m_done, "R10 acc_done", acc_done, m_done);
         a = addr_of(m_bank, m_row, m_col);
         if (m_cs) chk(int'(sram_addr) == a, "R1 R3 sram_addr", sram_addr, a);
         if (|m_we) chk(sram_wdata == m_wdata, "R4 sram_wdata", sram_wdata, m_wdata);
         if (m_rd) begin
            exp_d = hq[1][2] ? m_hold : word_at(a) & 16'hFF;
            chk(bus_rdata == exp_d, "R7 R8 bus_rdata", bus_rdata, exp_d);
         end
         if (|sram_we) begin
            a = int'(sram_addr);
            w = word_at(a);
            if (sram_we[0]) w[7:0] = sram_wdata;
            if (sram_we[1]) w[15:8] = sram_wdata;
            mem[a] = w;
            mem_gen++;
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic access(input int b, input int r, input int c, input logic [1:0] lanes,
                         input logic [7:0] wd, input bit poke,
                         output logic [7:0] lo, output logic [7:0] hi);
      int a = addr_of(b, r, c);
      int d0;
      @(negedge clk);
      bank_sel = b[0]; maddr = r[8:0]; ras_n = 0;
      repeat (4) @(negedge clk);
      maddr = c[8:0];
      repeat (2) @(negedge clk);
      cas_n = 0; bus_wdata = wd; wen_n = ~lanes;
      for (int k = 1; k <= 6; k++) begin
         @(negedge clk);
         if (k == 2) chk(sram_cs == 0, "R12 cs before third edge", sram_cs, 0);
         if (k == 3) chk(sram_cs == 1, "R12 cs at third edge", sram_cs, 1);
      end
      chk(int'(sram_addr) == a, "R1 R3 address in access", sram_addr, a);
      lo = bus_rdata;
      if (lanes == 0) chk(bus_oe == 1, "R7 read drives bus", bus_oe, 1);
      else chk(bus_oe == 0, "R9 write leaves bus undriven", bus_oe, 0);
      cas_n = 1; wen_n = 2'b11;
      repeat (6) @(negedge clk);
      if (poke) begin
         mem[a] = ~word_at(a); mem_gen++;
         @(negedge clk);
      end
      hi = bus_rdata;
      d0 = done_cnt;
      ras_n = 1;
      repeat (6) @(negedge clk);
      chk(done_cnt == d0 + 1, "R10 one done pulse", done_cnt - d0, 1);
   endtask

   initial begin
      logic [7:0] lo, hi;
      int a, c0, d0, w0;
      repeat (4) @(negedge clk);
      chk(sram_cs == 0 && bus_oe == 0 && sram_we == 0 && acc_done == 0,
          "R2 reset outputs idle", {sram_cs, bus_oe, sram_we, acc_done}, 0);
      rst_n = 1;
      repeat (4) @(negedge clk);

      // R4: byte writes to both lanes of one word, then read back
      access(0, 5, 7, 2'b01, 8'hA5, 0, lo, hi);
      access(0, 5, 7, 2'b10, 8'h3C, 0, lo, hi);
      access(0, 5, 7, 2'b00, 8'h00, 0, lo, hi);
      chk(lo == 8'hA5, "R4 lane0 written", lo, 8'hA5);
      chk(hi == 8'h3C, "R4 lane1 written", hi, 8'h3C);

      // R5: single-lane writes leave the other byte alone
      a = addr_of(0, 9'h1FF, 9'h100);
      access(0, 9'h1FF, 9'h100, 2'b10, 8'h77, 0, lo, hi);
      access(0, 9'h1FF, 9'h100, 2'b00, 8'h00, 0, lo, hi);
      chk(lo == pat_lo(a), "R5 lane0 untouched", lo, pat_lo(a));
      chk(hi == 8'h77, "R5 lane1 written", hi, 8'h77);
      a = addr_of(0, 9'h0AA, 9'h155);
      access(0, 9'h0AA, 9'h155, 2'b01, 8'hE1, 0, lo, hi);
      access(0, 9'h0AA, 9'h155, 2'b00, 8'h00, 0, lo, hi);
      chk(lo == 8'hE1, "R5 lane0 written", lo, 8'hE1);
      chk(hi == pat_hi(a), "R5 lane1 untouched", hi, pat_hi(a));

      // R3: the other bank at the same row and column is a different word
      a = addr_of(1, 5, 7);
      access(1, 5, 7, 2'b00, 8'h00, 0, lo, hi);
      chk(lo == pat_lo(a), "R3 bank1 lane0", lo, pat_lo(a));
      chk(hi == pat_hi(a), "R3 bank1 lane1", hi, pat_hi(a));

      // R6: refresh-only row cycles
      c0 = cs_rise_cnt; d0 = done_cnt; w0 = we_cnt;
      for (int r = 0; r < 3; r++) begin
         @(negedge clk); maddr = 9'(r * 37); wen_n = 2'b10; ras_n = 0;
         repeat (8) @(negedge clk);
         ras_n = 1; wen_n = 2'b11;
         repeat (6) @(negedge clk);
      end
      chk(cs_rise_cnt == c0, "R6 no chip select on refresh", cs_rise_cnt - c0, 0);
      chk(done_cnt == d0, "R6 no done on refresh", done_cnt - d0, 0);
      chk(we_cnt == w0, "R6 no write on refresh", we_cnt - w0, 0);

      // R8: second byte is held after the column strobe rises
      a = addr_of(0, 9'h033, 9'h044);
      access(0, 9'h033, 9'h044, 2'b00, 8'h00, 1, lo, hi);
      chk(lo == pat_lo(a), "R7 first byte", lo, pat_lo(a));
      chk(hi == pat_hi(a), "R8 held byte survives SRAM change", hi, pat_hi(a));

      // R11: short column-high period, then a new column in the same row cycle
      @(negedge clk);
      bank_sel = 0; maddr = 9'h010; ras_n = 0;
      repeat (4) @(negedge clk);
      maddr = 9'h020;
      repeat (2) @(negedge clk);
      cas_n = 0;
      repeat (6) @(negedge clk);
      cas_n = 1; maddr = 9'h021;
      @(negedge clk);
      cas_n = 0;
      repeat (6) @(negedge clk);
      a = addr_of(0, 9'h010, 9'h021);
      chk(int'(sram_addr) == a, "R11 new column taken", sram_addr, a);
      chk(bus_rdata == pat_lo(a), "R11 first byte of new column", bus_rdata, pat_lo(a));
      cas_n = 1;
      repeat (6) @(negedge clk);
      chk(bus_rdata == pat_hi(a), "R11 held byte of new column", bus_rdata, pat_hi(a));
      cas_n = 0;
      @(negedge clk);
      cas_n = 1;
      @(negedge clk);
      ras_n = 1;
      repeat (8) @(negedge clk);
      access(0, 5, 7, 2'b00, 8'h00, 0, lo, hi);
      chk(lo == 8'hA5 && hi == 8'h3C, "R11 state intact after early end", {hi, lo}, 16'h3CA5);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_err++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule